// File: doc/BRIEF.md
# Slot-Locked Hardware Thread Scheduler

This block runs up to four hardware threads on one core of an eight-core system. A round-robin hub grants that core one access slot in every eight clocks, and it marks each grant with a one-cycle strobe. The scheduler changes the running thread only when that strobe arrives. Each thread therefore owns a fixed and predictable share of the core's clocks and of its hub bandwidth. The thread count is chosen by a two-bit mode input. The block reports the running thread, the program counter saved for that thread, and the base and limit of that thread's slice of the core's 512-word register memory.

The core's execution unit gives the block thread-relative register addresses. The scheduler turns them into physical addresses within the running thread's window. Addresses in the 16-word I/O register region at the top of the space (0x1F0 to 0x1FF) pass through unchanged, because every thread shares that region. An address that reaches past the window's limit is flagged, and the access is refused. Relocation is combinational and has no handshake: the result applies in the same cycle as the request. The program counters are registers, one per thread. The core writes the running thread's PC with a load strobe. The other threads' PCs stay as they were until those threads run again.

Top module: `hub_thread_sched`

## Requirements
- R1: After reset the block is in single-thread mode: act_tid is 0, act_base is 0x000, act_limit is 0x1EF and act_pc is 0x000.
- R2: act_tid changes only in the cycle that follows a clock edge at which hub_slot was 1 or mode_sel differed from the mode in effect. In every other cycle act_tid holds its value.
- R3: mode_sel 2'b00 selects single-thread mode. Thread 0 runs in every slot, with window 0x000–0x1EF.
- R4: mode_sel 2'b01 selects two threads. The owner alternates 0,1 on each slot. Thread 0 has window 0x000–0x0FF and thread 1 has window 0x100–0x1EF.
- R5: mode_sel 2'b10 selects three threads. Slot owners repeat 0,1,0,2. The windows are thread 0 0x000–0x0FF, thread 1 0x100–0x17F and thread 2 0x180–0x1EF.
- R6: mode_sel 2'b11 selects four threads. Slot owners repeat 0,1,2,3. The windows are 0x000–0x07F, 0x080–0x0FF, 0x100–0x17F and 0x180–0x1EF.
- R7: If mode_sel differs from the mode in effect at a clock edge, then in the next cycle the new mode applies, the running thread is 0, the rotation restarts, and every thread's PC equals its window base under the new mode. This restart takes priority over a hub_slot or pc_load in the same cycle.
- R8: pc_load writes pc_next into the PC of the thread running in that cycle. It does this also when hub_slot is 1 in the same cycle. act_pc always shows the running thread's saved PC, and the PC of a thread that is not running keeps its value.
- R9: For rel_addr below 0x1F0, phys_addr is act_base plus rel_addr. If that sum is at most act_limit, acc_ok equals rel_valid and addr_err is 0.
- R10: For rel_addr in 0x1F0–0x1FF, phys_addr equals rel_addr for any thread and mode, and acc_ok equals rel_valid.
- R11: For rel_addr below 0x1F0 whose relocated address exceeds act_limit, addr_err equals rel_valid and acc_ok is 0. When rel_valid is 0, both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Thread-count selection (00 one, 01 two, 10 three, 11 four) |
| hub_slot | input | 1 | One-cycle strobe marking this core's hub slot |
| pc_load | input | 1 | Write pc_next into the running thread's PC |
| pc_next | input | 9 | New PC value for the running thread |
| rel_valid | input | 1 | A thread-relative register access is requested |
| rel_addr | input | 9 | Thread-relative register address |
| act_tid | output | 2 | Running thread |
| act_pc | output | 9 | Saved PC of the running thread |
| act_base | output | 9 | First word of the running thread's window |
| act_limit | output | 9 | Last word of the running thread's window |
| phys_addr | output | 9 | Relocated physical register address |
| addr_err | output | 1 | Request falls outside the running thread's window |
| acc_ok | output | 1 | Request is granted |

## Verification
Two situations are the hardest to reach from the ports: a PC write that lands in the same cycle as a slot, and a mode change that coincides with both a slot and a PC write. In the first case the write must reach the outgoing thread. In the second the restart must override both. The stimulus runs the four-thread rotation and loads thread 0 in the cycle of its slot, then comes back around to thread 0 to show that the saved value survived. Later, mode_sel, hub_slot and pc_load are all raised together, and the bench confirms that thread 0 starts at its base and that the next thread starts at its own base.

// File: rtl/hts_pkg.sv
package hts_pkg;
  localparam int ADDR_W   = 9;
  localparam int TID_W    = 2;
  localparam int NTHR     = 1 << TID_W;
  localparam int IO_WORDS = 16;
  localparam int SPACE    = 1 << ADDR_W;
  localparam int HALF     = SPACE / 2;
  localparam int QTR      = SPACE / 4;
  localparam int IO_BASE  = SPACE - IO_WORDS;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [TID_W-1:0]  tid_t;
  typedef logic [1:0]        pos_t;

  typedef enum logic [1:0] {
    MODE_ONE   = 2'd0,
    MODE_TWO   = 2'd1,
    MODE_THREE = 2'd2,
    MODE_FOUR  = 2'd3
  } mode_e;

  // first word of a thread's window under a given mode
  function automatic addr_t win_base(mode_e m, tid_t t);
    addr_t b;
    b = '0;
    case (m)
      MODE_TWO:   b = (t == tid_t'(1)) ? addr_t'(HALF) : '0;
      MODE_THREE: begin
        if (t == tid_t'(1))      b = addr_t'(HALF);
        else if (t == tid_t'(2)) b = addr_t'(HALF + QTR);
        else                     b = '0;
      end
      MODE_FOUR:  b = addr_t'(int'(t) * QTR);
      default:    b = '0;
    endcase
    return b;
  endfunction

  // last word of a thread's window; the final window stops below the I/O area
  function automatic addr_t win_limit(mode_e m, tid_t t);
    addr_t l;
    l = addr_t'(IO_BASE - 1);
    case (m)
      MODE_TWO:   if (t == tid_t'(0)) l = addr_t'(HALF - 1);
      MODE_THREE: begin
        if (t == tid_t'(0))      l = addr_t'(HALF - 1);
        else if (t == tid_t'(1)) l = addr_t'(HALF + QTR - 1);
      end
      MODE_FOUR:  if (t != tid_t'(NTHR - 1)) l = addr_t'(int'(t) * QTR + QTR - 1);
      default:    l = addr_t'(IO_BASE - 1);
    endcase
    return l;
  endfunction

  // owner of slot position p in the repeating four-slot frame
  function automatic tid_t slot_owner(mode_e m, pos_t p);
    tid_t o;
    case (m)
      MODE_TWO:   o = tid_t'(p[0]);
      MODE_THREE: o = !p[0] ? tid_t'(0) : (p[1] ? tid_t'(2) : tid_t'(1));
      MODE_FOUR:  o = tid_t'(p);
      default:    o = '0;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/hts_rotor.sv
module hts_rotor
  import hts_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode_sel,
  input  logic  hub_slot,
  output mode_e mode_q,
  output tid_t  tid,
  output logic  restart
);
  pos_t pos;

  assign restart = (mode_sel != mode_q);
  assign tid     = slot_owner(mode_q, pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_ONE;
      pos    <= '0;
    end else if (restart) begin
      mode_q <= mode_sel;
      pos    <= '0;
    end else if (hub_slot) begin
      pos <= pos + pos_t'(1);
    end
  end

  // R2
  tid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hub_slot && !restart) |=> $stable(tid));

  // R6
  four_rr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FOUR && hub_slot && !restart) |=> (tid == tid_t'($past(tid) + tid_t'(1))));

  // R5
  three_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_THREE && hub_slot && !restart && tid != tid_t'(0)) |=> (tid == tid_t'(0)));
endmodule

// File: rtl/hts_pc_bank.sv
module hts_pc_bank
  import hts_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  mode_e new_mode,
  input  tid_t  tid,
  input  logic  pc_load,
  input  addr_t pc_next,
  output addr_t act_pc
);
  addr_t pc_r [NTHR];

  for (genvar g = 0; g < NTHR; g++) begin : g_pc
    always_ff @(posedge clk) begin
      if (!rst_n)
        pc_r[g] <= win_base(MODE_ONE, tid_t'(g));
      else if (restart)
        pc_r[g] <= win_base(new_mode, tid_t'(g));
      else if (pc_load && tid == tid_t'(g))
        pc_r[g] <= pc_next;
    end
  end

  assign act_pc = pc_r[tid];
endmodule

// File: rtl/hts_reloc.sv
module hts_reloc
  import hts_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t base,
  input  addr_t limit,
  input  logic  rel_valid,
  input  addr_t rel_addr,
  output addr_t phys_addr,
  output logic  addr_err,
  output logic  acc_ok
);
  logic              io_hit;
  logic [ADDR_W:0]   sum;
  logic              over;

  always_comb begin
    io_hit    = (rel_addr >= addr_t'(IO_BASE));
    sum       = {1'b0, base} + {1'b0, rel_addr};
    over      = !io_hit && (sum > {1'b0, limit});
    phys_addr = io_hit ? rel_addr : sum[ADDR_W-1:0];
    addr_err  = rel_valid && over;
    acc_ok    = rel_valid && !over;
  end

  // R9
  grant_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |-> (phys_addr >= addr_t'(IO_BASE) || (phys_addr >= base && phys_addr <= limit)));

  // R10
  io_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && rel_addr >= addr_t'(IO_BASE)) |-> (acc_ok && !addr_err && phys_addr == rel_addr));
endmodule

// File: rtl/hub_thread_sched.sv
module hub_thread_sched
  import hts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             hub_slot,
  input  logic             pc_load,
  input  logic [8:0]       pc_next,
  input  logic             rel_valid,
  input  logic [8:0]       rel_addr,
  output logic [1:0]       act_tid,
  output logic [8:0]       act_pc,
  output logic [8:0]       act_base,
  output logic [8:0]       act_limit,
  output logic [8:0]       phys_addr,
  output logic             addr_err,
  output logic             acc_ok
);
  mode_e mode_q;
  mode_e mode_in;
  tid_t  tid;
  logic  restart;
  addr_t pc_w;
  addr_t base_w;
  addr_t limit_w;

  assign mode_in = mode_e'(mode_sel);

  hts_rotor u_rotor (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_in),
    .hub_slot (hub_slot),
    .mode_q   (mode_q),
    .tid      (tid),
    .restart  (restart)
  );

  hts_pc_bank u_pcs (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .new_mode (mode_in),
    .tid      (tid),
    .pc_load  (pc_load),
    .pc_next  (pc_next),
    .act_pc   (pc_w)
  );

  assign base_w  = win_base(mode_q, tid);
  assign limit_w = win_limit(mode_q, tid);

  hts_reloc u_reloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .base      (base_w),
    .limit     (limit_w),
    .rel_valid (rel_valid),
    .rel_addr  (rel_addr),
    .phys_addr (phys_addr),
    .addr_err  (addr_err),
    .acc_ok    (acc_ok)
  );

  assign act_tid   = tid;
  assign act_pc    = pc_w;
  assign act_base  = base_w;
  assign act_limit = limit_w;

  // R7
  restart_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (act_tid == 2'd0 && act_pc == act_base));

  // R8
  pc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !restart && !hub_slot) |=> (act_pc == $past(pc_next)));
endmodule

// File: tb/test_hub_thread_sched.sv
module test_hub_thread_sched;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       hub_slot;
  logic       pc_load;
  logic [8:0] pc_next;
  logic       rel_valid;
  logic [8:0] rel_addr;
  logic [1:0] act_tid;
  logic [8:0] act_pc, act_base, act_limit, phys_addr;
  logic       addr_err, acc_ok;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hub_thread_sched i_hub_thread_sched (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .hub_slot(hub_slot),
    .pc_load(pc_load), .pc_next(pc_next), .rel_valid(rel_valid), .rel_addr(rel_addr),
    .act_tid(act_tid), .act_pc(act_pc), .act_base(act_base), .act_limit(act_limit),
    .phys_addr(phys_addr), .addr_err(addr_err), .acc_ok(acc_ok)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic slot();
    hub_slot = 1'b1;
    step();
    hub_slot = 1'b0;
  endtask

  task automatic check_thread(string tag, int t, int b, int l);
    check({tag, " tid"}, act_tid, t);
    check({tag, " base"}, act_base, b);
    check({tag, " limit"}, act_limit, l);
  endtask

  task automatic t_reset();
    check_thread("R1", 0, 'h000, 'h1EF);
    check("R1 pc", act_pc, 'h000);
  endtask

  task automatic t_single();
    for (int i = 0; i < 3; i++) begin
      slot();
      check_thread("R3", 0, 'h000, 'h1EF);
    end
  endtask

  task automatic t_mode2();
    mode_sel = 2'b01;
    step();
    check_thread("R7 enter two", 0, 'h000, 'h0FF);
    check("R7 pc t0", act_pc, 'h000);
    step();
    check("R2 hold", act_tid, 0);
    slot();
    check_thread("R4 t1", 1, 'h100, 'h1EF);
    check("R7 pc t1", act_pc, 'h100);
    step(); step();
    check("R2 hold t1", act_tid, 1);
    slot();
    check_thread("R4 back", 0, 'h000, 'h0FF);
  endtask

  task automatic t_mode3();
    int exp_t [5] = '{0, 1, 0, 2, 0};
    int exp_b [3] = '{'h000, 'h100, 'h180};
    int exp_l [3] = '{'h0FF, 'h17F, 'h1EF};
    mode_sel = 2'b10;
    step();
    for (int i = 0; i < 5; i++) begin
      check_thread("R5", exp_t[i], exp_b[exp_t[i]], exp_l[exp_t[i]]);
      if (i < 4) slot();
    end
  endtask

  task automatic t_mode4();
    int exp_l [4] = '{'h07F, 'h0FF, 'h17F, 'h1EF};
    mode_sel = 2'b11;
    step();
    for (int i = 0; i < 5; i++) begin
      check_thread("R6", i % 4, (i % 4) * 'h80, exp_l[i % 4]);
      if (i < 4) slot();
    end
  endtask

  task automatic t_pc();
    pc_load = 1'b1; pc_next = 9'h012;
    step();
    check("R8 load", act_pc, 'h012);
    pc_next = 9'h013; hub_slot = 1'b1;
    step();
    pc_load = 1'b0; hub_slot = 1'b0;
    check("R8 incoming t1", act_pc, 'h080);
    slot();
    check("R8 t2", act_pc, 'h100);
    slot();
    check("R8 t3", act_pc, 'h180);
    slot();
    check("R8 t0 kept", act_pc, 'h013);
  endtask

  task automatic t_reloc();
    mode_sel = 2'b01;
    step();
    rel_valid = 1'b1;
    rel_addr = 9'h040; #1;
    check("R9 phys", phys_addr, 'h040); check("R9 ok", acc_ok, 1);
    rel_addr = 9'h0FF; #1;
    check("R9 edge ok", acc_ok, 1); check("R9 edge err", addr_err, 0);
    rel_addr = 9'h100; #1;
    check("R11 err", addr_err, 1); check("R11 ok", acc_ok, 0);
    rel_addr = 9'h1F5; #1;
    check("R10 phys", phys_addr, 'h1F5); check("R10 ok", acc_ok, 1);
    rel_valid = 1'b0; rel_addr = 9'h100; #1;
    check("R11 idle err", addr_err, 0); check("R11 idle ok", acc_ok, 0);
    slot();
    rel_valid = 1'b1;
    rel_addr = 9'h020; #1;
    check("R9 t1 phys", phys_addr, 'h120); check("R9 t1 ok", acc_ok, 1);
    rel_addr = 9'h0EF; #1;
    check("R9 t1 edge", phys_addr, 'h1EF); check("R9 t1 edge ok", acc_ok, 1);
    rel_addr = 9'h0F0; #1;
    check("R11 t1 err", addr_err, 1); check("R11 t1 ok", acc_ok, 0);
    rel_addr = 9'h1FF; #1;
    check("R10 t1 phys", phys_addr, 'h1FF); check("R10 t1 ok", acc_ok, 1);
    rel_valid = 1'b0;
  endtask

  task automatic t_prio();
    check("R7 pre tid", act_tid, 1);
    mode_sel = 2'b11; hub_slot = 1'b1; pc_load = 1'b1; pc_next = 9'h055;
    step();
    hub_slot = 1'b0; pc_load = 1'b0;
    check_thread("R7 prio", 0, 'h000, 'h07F);
    check("R7 prio pc", act_pc, 'h000);
    slot();
    check("R7 t1 base pc", act_pc, 'h080);
    check("R7 t1 tid", act_tid, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'b00; hub_slot = 1'b0; pc_load = 1'b0;
    pc_next = '0; rel_valid = 1'b0; rel_addr = '0;
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_single();
    t_mode2();
    t_mode3();
    t_mode4();
    t_pc();
    t_reloc();
    t_prio();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule